// File: doc/BRIEF.md
# Display Page Writer

This block sends rectangular runs of a monochrome frame image to a page-addressed display controller over a write-only SPI link. A request names a page (a band of eight pixel rows), a starting logical column and a byte count. The block first sends three addressing commands with the command/data line high. It then lowers that line and streams the requested bytes from a local frame memory through a combinational read port. Each byte holds one vertical column of eight pixels of the chosen page.

The visible panel is 96 columns wide, but the controller drives 132 segments. A fixed offset of 18 is therefore added to every logical column before the column is split into the two column-address commands. Runs that would pass the right edge are clipped. A clear request repeats the address-and-burst sequence for every page, from page 0 upward. Each page is sent at full width under one continuous chip-select frame.

Top module: `lcd_page_writer`

## Requirements
- R1: During reset and on the first cycle after it, `spi_cs_n` is 1, `spi_sclk` is 0, `busy` is 0 and `req_ready` is 1.
- R2: SPI mode 0, MSB first, 8 bits per byte. `spi_sclk` idles low whenever `busy` is 0. `spi_mosi` changes only while `spi_sclk` is low, so it is stable at every rising edge.
- R3: The three command bytes of a run are sent in this order: `0xB0 + page`, then `0x00 | devcol[3:0]`, then `0x10 | devcol[7:4]`, where devcol = column + 18.
- R4: `spi_dc` is 1 for the three command bytes and 0 for the data bytes. It never changes while `spi_sclk` is high.
- R5: The data burst has exactly min(len, 96 - col) bytes, read from frame addresses page*96 + col upward in ascending order.
- R6: A request whose clipped length is 0 (len = 0, or col >= 96) is accepted but sends no bytes and never asserts `spi_cs_n`. `busy` then returns to 0.
- R7: A clear request (`req_clear` = 1) ignores the page, column and length inputs. It sends pages 0 to 7 in ascending order. Each page gets its command bytes with devcol 18, followed by 96 data bytes from page*96 upward, all within one chip-select frame.
- R8: `spi_cs_n` stays low from before the first clock of the first command byte until after the last data bit. Between two frames it stays high for at least one SPI clock period (2*SCLK_HALF system cycles).
- R9: `req_ready` equals the inverse of `busy`. A request is taken when `req_valid` and `req_ready` are both 1, and `busy` is 1 on the next cycle. `req_valid` while busy has no effect.
- R10: `spi_sclk` is high only while `spi_cs_n` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can take a request |
| req_clear | input | 1 | Clear request: send every page at full width |
| req_page | input | PAGE_W (3) | Target page |
| req_col | input | COL_W (7) | Logical start column |
| req_len | input | LEN_W (7) | Requested byte count before clipping |
| busy | output | 1 | A transfer or the trailing deselect gap is in progress |
| mem_addr | output | ADDR_W (10) | Frame memory read address |
| mem_rdata | input | 8 | Frame memory byte at `mem_addr` (combinational read) |
| spi_sclk | output | 1 | SPI clock, mode 0 |
| spi_mosi | output | 1 | SPI data out, MSB first |
| spi_cs_n | output | 1 | Chip select, active low |
| spi_dc | output | 1 | 1 = command byte, 0 = pixel data byte |

## Verification
The bound checker watches the link's electrical rules on every cycle:
- SCLK idles low and pulses only under chip select.
- MOSI and the command/data line hold steady while SCLK is high.
- `req_ready` mirrors `busy`, and `busy` rises after an accepted request.
- The chip-select high gap is long enough.
- The reset state is correct.

The scenarios must show the byte content itself: the page and split column opcodes with the offset and its nibble carry, the clipped burst length and its memory addresses, the eight-page order of a clear, the silent handling of empty runs, and that requests arriving mid-transfer leave no trace on the wire.

// File: rtl/lcdw_pkg.sv
package lcdw_pkg;

    typedef enum logic [1:0] {
        SQ_IDLE = 2'd0,
        SQ_CMD  = 2'd1,
        SQ_DATA = 2'd2,
        SQ_GAP  = 2'd3
    } seq_state_e;

    // One byte queued for the shifter, tagged with the command/data level it needs
    typedef struct packed {
        logic       is_cmd;
        logic [7:0] value;
    } spi_item_t;

    localparam int CMD_BYTES = 3;

endpackage

// File: rtl/lcdw_spi_tx.sv
module lcdw_spi_tx #(
    parameter int SCLK_HALF = 2,
    parameter int DIV_W     = (SCLK_HALF > 1) ? $clog2(SCLK_HALF) : 1
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       load,
    input  logic [7:0] din,
    output logic       sclk,
    output logic       mosi,
    output logic       done
);
    logic [7:0]       sh_q;
    logic [2:0]       bit_q;
    logic [DIV_W-1:0] div_q;
    logic             act_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sh_q  <= '0;
            bit_q <= '0;
            div_q <= '0;
            act_q <= 1'b0;
            sclk  <= 1'b0;
            done  <= 1'b0;
        end else begin
            done <= 1'b0;
            if (load) begin
                sh_q  <= din;
                bit_q <= '0;
                div_q <= '0;
                act_q <= 1'b1;
                sclk  <= 1'b0;
            end else if (act_q) begin
                if (div_q == DIV_W'(SCLK_HALF - 1)) begin
                    div_q <= '0;
                    if (!sclk) begin
                        sclk <= 1'b1;
                    end else begin
                        // falling edge: present the next bit
                        sclk <= 1'b0;
                        sh_q <= {sh_q[6:0], 1'b0};
                        if (bit_q == 3'd7) begin
                            act_q <= 1'b0;
                            done  <= 1'b1;
                        end else begin
                            bit_q <= bit_q + 3'd1;
                        end
                    end
                end else begin
                    div_q <= div_q + DIV_W'(1);
                end
            end
        end
    end

    assign mosi = sh_q[7];
endmodule

// File: rtl/lcdw_cmd_fmt.sv
module lcdw_cmd_fmt #(
    parameter int         PAGE_W  = 3,
    parameter int         COL_W   = 7,
    parameter int         COL_OFS = 18,
    parameter logic [7:0] PAGE_OP = 8'hB0,
    parameter logic [7:0] LO_OP   = 8'h00,
    parameter logic [7:0] HI_OP   = 8'h10
) (
    input  logic [PAGE_W-1:0] page,
    input  logic [COL_W-1:0]  col,
    input  logic [1:0]        idx,
    output logic [7:0]        cmd
);
    logic [7:0] devcol;

    assign devcol = 8'(col) + 8'(COL_OFS);

    always_comb begin
        unique case (idx)
            2'd0:    cmd = PAGE_OP + 8'(page);
            2'd1:    cmd = LO_OP | {4'h0, devcol[3:0]};
            default: cmd = HI_OP | {4'h0, devcol[7:4]};
        endcase
    end
endmodule

// File: rtl/lcdw_seq.sv
module lcdw_seq
    import lcdw_pkg::*;
#(
    parameter int COLS      = 96,
    parameter int PAGES     = 8,
    parameter int SCLK_HALF = 2,
    parameter int PAGE_W    = $clog2(PAGES),
    parameter int COL_W     = $clog2(COLS),
    parameter int LEN_W     = $clog2(COLS + 1),
    parameter int ADDR_W    = $clog2(PAGES * COLS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_clear,
    input  logic [PAGE_W-1:0] req_page,
    input  logic [COL_W-1:0]  req_col,
    input  logic [LEN_W-1:0]  req_len,
    output logic              busy,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic [7:0]        mem_rdata,
    output logic [PAGE_W-1:0] cur_page,
    output logic [COL_W-1:0]  cur_col,
    output logic [1:0]        cmd_idx,
    input  logic [7:0]        cmd_byte,
    output logic              tx_load,
    output spi_item_t         tx_item,
    input  logic              tx_done,
    output logic              cs_n
);
    localparam int GAP_CYC = 2 * SCLK_HALF;
    localparam int GAP_W   = $clog2(GAP_CYC + 1);

    seq_state_e        state_q;
    logic [LEN_W-1:0]  remain_q;
    logic              clr_q;
    logic              infl_q;
    logic [GAP_W-1:0]  gap_q;
    logic [LEN_W-1:0]  room;
    logic [LEN_W-1:0]  clip_len;

    always_comb begin
        room     = LEN_W'(COLS) - LEN_W'(req_col);
        clip_len = (32'(req_col) >= COLS) ? '0 :
                   ((req_len < room) ? req_len : room);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= SQ_IDLE;
            cs_n     <= 1'b1;
            tx_load  <= 1'b0;
            tx_item  <= '0;
            cur_page <= '0;
            cur_col  <= '0;
            cmd_idx  <= '0;
            remain_q <= '0;
            clr_q    <= 1'b0;
            infl_q   <= 1'b0;
            mem_addr <= '0;
            gap_q    <= '0;
        end else begin
            tx_load <= 1'b0;
            unique case (state_q)
                SQ_IDLE: begin
                    infl_q  <= 1'b0;
                    cmd_idx <= '0;
                    if (req_valid) begin
                        if (req_clear) begin
                            cur_page <= '0;
                            cur_col  <= '0;
                            remain_q <= LEN_W'(COLS);
                            clr_q    <= 1'b1;
                            cs_n     <= 1'b0;
                            state_q  <= SQ_CMD;
                        end else if (clip_len == '0) begin
                            gap_q   <= '0;
                            state_q <= SQ_GAP;
                        end else begin
                            cur_page <= req_page;
                            cur_col  <= req_col;
                            remain_q <= clip_len;
                            clr_q    <= 1'b0;
                            cs_n     <= 1'b0;
                            state_q  <= SQ_CMD;
                        end
                    end
                end
                SQ_CMD: begin
                    if (!infl_q) begin
                        tx_load <= 1'b1;
                        tx_item <= '{is_cmd: 1'b1, value: cmd_byte};
                        infl_q  <= 1'b1;
                    end else if (tx_done) begin
                        infl_q <= 1'b0;
                        if (cmd_idx == 2'(CMD_BYTES - 1)) begin
                            state_q  <= SQ_DATA;
                            mem_addr <= ADDR_W'(cur_page) * ADDR_W'(COLS) + ADDR_W'(cur_col);
                        end else begin
                            cmd_idx <= cmd_idx + 2'd1;
                        end
                    end
                end
                SQ_DATA: begin
                    if (!infl_q) begin
                        tx_load  <= 1'b1;
                        tx_item  <= '{is_cmd: 1'b0, value: mem_rdata};
                        infl_q   <= 1'b1;
                        mem_addr <= mem_addr + ADDR_W'(1);
                        remain_q <= remain_q - LEN_W'(1);
                    end else if (tx_done) begin
                        infl_q <= 1'b0;
                        if (remain_q == '0) begin
                            if (clr_q && cur_page != PAGE_W'(PAGES - 1)) begin
                                cur_page <= cur_page + PAGE_W'(1);
                                cur_col  <= '0;
                                remain_q <= LEN_W'(COLS);
                                cmd_idx  <= '0;
                                state_q  <= SQ_CMD;
                            end else begin
                                cs_n    <= 1'b1;
                                gap_q   <= '0;
                                state_q <= SQ_GAP;
                            end
                        end
                    end
                end
                default: begin
                    gap_q <= gap_q + GAP_W'(1);
                    if (gap_q == GAP_W'(GAP_CYC - 1)) state_q <= SQ_IDLE;
                end
            endcase
        end
    end

    assign busy      = (state_q != SQ_IDLE);
    assign req_ready = (state_q == SQ_IDLE);
endmodule

// File: rtl/lcd_page_writer.sv
module lcd_page_writer
    import lcdw_pkg::*;
#(
    parameter int         COLS      = 96,
    parameter int         PAGES     = 8,
    parameter int         COL_OFS   = 18,
    parameter int         SCLK_HALF = 2,
    parameter logic [7:0] PAGE_OP   = 8'hB0,
    parameter logic [7:0] LO_OP     = 8'h00,
    parameter logic [7:0] HI_OP     = 8'h10,
    parameter int         PAGE_W    = $clog2(PAGES),
    parameter int         COL_W     = $clog2(COLS),
    parameter int         LEN_W     = $clog2(COLS + 1),
    parameter int         ADDR_W    = $clog2(PAGES * COLS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_clear,
    input  logic [PAGE_W-1:0] req_page,
    input  logic [COL_W-1:0]  req_col,
    input  logic [LEN_W-1:0]  req_len,
    output logic              busy,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic [7:0]        mem_rdata,
    output logic              spi_sclk,
    output logic              spi_mosi,
    output logic              spi_cs_n,
    output logic              spi_dc
);
    logic [PAGE_W-1:0] cur_page;
    logic [COL_W-1:0]  cur_col;
    logic [1:0]        cmd_idx;
    logic [7:0]        cmd_byte;
    logic              tx_load;
    logic              tx_done;
    spi_item_t         tx_item;

    lcdw_seq #(
        .COLS(COLS), .PAGES(PAGES), .SCLK_HALF(SCLK_HALF),
        .PAGE_W(PAGE_W), .COL_W(COL_W), .LEN_W(LEN_W), .ADDR_W(ADDR_W)
    ) seq_i (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_ready(req_ready), .req_clear(req_clear),
        .req_page(req_page), .req_col(req_col), .req_len(req_len),
        .busy(busy), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
        .cur_page(cur_page), .cur_col(cur_col), .cmd_idx(cmd_idx),
        .cmd_byte(cmd_byte), .tx_load(tx_load), .tx_item(tx_item),
        .tx_done(tx_done), .cs_n(spi_cs_n)
    );

    lcdw_cmd_fmt #(
        .PAGE_W(PAGE_W), .COL_W(COL_W), .COL_OFS(COL_OFS),
        .PAGE_OP(PAGE_OP), .LO_OP(LO_OP), .HI_OP(HI_OP)
    ) fmt_i (
        .page(cur_page), .col(cur_col), .idx(cmd_idx), .cmd(cmd_byte)
    );

    lcdw_spi_tx #(.SCLK_HALF(SCLK_HALF)) tx_i (
        .clk(clk), .rst(rst), .load(tx_load), .din(tx_item.value),
        .sclk(spi_sclk), .mosi(spi_mosi), .done(tx_done)
    );

    assign spi_dc = tx_item.is_cmd;
endmodule

// File: rtl/lcd_page_writer_chk.sv
module lcd_page_writer_chk #(
    parameter int SCLK_HALF = 2
) (
    input logic clk,
    input logic rst,
    input logic req_valid,
    input logic req_ready,
    input logic busy,
    input logic spi_sclk,
    input logic spi_mosi,
    input logic spi_cs_n,
    input logic spi_dc
);
    logic [15:0] hi_cnt;

    // cycles spent with chip select high, saturating
    always_ff @(posedge clk) begin
        if (rst)              hi_cnt <= '1;
        else if (!spi_cs_n)   hi_cnt <= '0;
        else if (hi_cnt != '1) hi_cnt <= hi_cnt + 16'd1;
    end

    p_reset_state_r1: assert property (@(posedge clk)
        rst |=> (spi_cs_n && !spi_sclk && !busy && req_ready));

    p_sclk_idle_r2: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !spi_sclk);

    p_mosi_steady_r2: assert property (@(posedge clk) disable iff (rst)
        spi_sclk |-> $stable(spi_mosi));

    p_dc_steady_r4: assert property (@(posedge clk) disable iff (rst)
        spi_sclk |-> $stable(spi_dc));

    p_cs_gap_r8: assert property (@(posedge clk) disable iff (rst)
        $fell(spi_cs_n) |-> (32'(hi_cnt) >= 2 * SCLK_HALF));

    p_ready_mirror_r9: assert property (@(posedge clk) disable iff (rst)
        req_ready != busy);

    p_accept_busy_r9: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> busy);

    p_sclk_under_cs_r10: assert property (@(posedge clk) disable iff (rst)
        spi_sclk |-> !spi_cs_n);
endmodule

bind lcd_page_writer lcd_page_writer_chk #(.SCLK_HALF(SCLK_HALF)) chk_i (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .busy(busy), .spi_sclk(spi_sclk), .spi_mosi(spi_mosi),
    .spi_cs_n(spi_cs_n), .spi_dc(spi_dc)
);

// File: tb/lcd_page_writer_tb_top.sv
module lcd_page_writer_tb_top;
    localparam int COLS = 96;
    localparam int PAGES = 8;
    localparam int HALF = 2;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       req_valid = 1'b0;
    logic       req_ready;
    logic       req_clear = 1'b0;
    logic [2:0] req_page = '0;
    logic [6:0] req_col = '0;
    logic [6:0] req_len = '0;
    logic       busy;
    logic [9:0] mem_addr;
    logic [7:0] mem_rdata;
    logic       spi_sclk, spi_mosi, spi_cs_n, spi_dc;

    int nvec = 0;
    int nfail = 0;
    int frames = 0;
    int bitn = 0;
    logic [7:0] shv;
    realtime t_rise = -1.0e9;
    logic [8:0] exp_q[$];
    string cur_tag = "R1";

    always #5 clk = ~clk;

    function automatic logic [7:0] mem_f(int a);
        return 8'((a * 37 + 11) ^ (a >> 3));
    endfunction

    assign mem_rdata = mem_f(int'(mem_addr));

    lcd_page_writer dut_i (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_clear(req_clear), .req_page(req_page), .req_col(req_col),
        .req_len(req_len), .busy(busy), .mem_addr(mem_addr),
        .mem_rdata(mem_rdata), .spi_sclk(spi_sclk), .spi_mosi(spi_mosi),
        .spi_cs_n(spi_cs_n), .spi_dc(spi_dc)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        nvec++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    // monitor: rebuild bytes at rising SCLK and compare with the scoreboard
    always @(posedge spi_sclk) begin
        check(!spi_cs_n, "R10 sclk with cs high", int'(spi_cs_n), 0);
        shv = {shv[6:0], spi_mosi};
        bitn++;
        if (bitn == 8) begin
            bitn = 0;
            if (exp_q.size() == 0) begin
                check(1'b0, {cur_tag, " extra byte"}, int'({spi_dc, shv}), -1);
            end else begin
                logic [8:0] e;
                e = exp_q.pop_front();
                check(spi_dc == e[8], "R4 dc level", int'(spi_dc), int'(e[8]));
                check(shv == e[7:0], e[8] ? "R3 command byte" : {cur_tag, " data byte"},
                      int'(shv), int'(e[7:0]));
            end
        end
    end

    always @(posedge spi_cs_n) t_rise = $realtime;
    always @(negedge spi_cs_n) begin
        frames++;
        check(($realtime - t_rise) >= real'(2 * HALF * 10), "R8 deselect gap",
              int'($realtime - t_rise), 2 * HALF * 10);
    end

    task automatic push_run(input int page, input int col, input int n);
        int dcol;
        dcol = col + 18;
        exp_q.push_back({1'b1, 8'(8'hB0 + page)});
        exp_q.push_back({1'b1, 8'(8'h00 | (dcol & 15))});
        exp_q.push_back({1'b1, 8'(8'h10 | (dcol >> 4))});
        for (int i = 0; i < n; i++)
            exp_q.push_back({1'b0, mem_f(page * COLS + col + i)});
    endtask

    task automatic send(input int page, input int col, input int len,
                        input bit clr, input bit jam, input string tag);
        int n, f0, efr;
        while (busy) @(negedge clk);
        cur_tag = tag;
        if (clr) begin
            for (int p = 0; p < PAGES; p++) push_run(p, 0, COLS);
            efr = 1;
        end else begin
            n = (col >= COLS) ? 0 : ((len < COLS - col) ? len : COLS - col);
            if (n > 0) push_run(page, col, n);
            efr = (n > 0) ? 1 : 0;
        end
        f0 = frames;
        @(negedge clk);
        check(req_ready == 1'b1, "R9 ready when idle", int'(req_ready), 1);
        req_valid = 1'b1; req_clear = clr;
        req_page = 3'(page); req_col = 7'(col); req_len = 7'(len);
        @(negedge clk);
        req_valid = 1'b0; req_clear = 1'b0;
        check(busy == 1'b1 && req_ready == 1'b0, "R9 busy after accept", int'(busy), 1);
        if (jam) begin
            // a different request held while busy must leave no trace
            req_valid = 1'b1; req_clear = 1'b1;
            req_page = 3'd5; req_col = 7'd3; req_len = 7'd10;
            repeat (40) @(negedge clk);
            req_valid = 1'b0; req_clear = 1'b0;
        end
        while (busy) @(negedge clk);
        repeat (2) @(negedge clk);
        check(exp_q.size() == 0, {tag, " missing bytes"}, exp_q.size(), 0);
        exp_q.delete();
        check(frames - f0 == efr, {tag, " cs frames"}, frames - f0, efr);
        check(spi_cs_n && !spi_sclk, "R2 idle lines", int'({spi_cs_n, spi_sclk}), 2);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        check(1'b0, "watchdog", 0, 1);
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check(spi_cs_n && !spi_sclk && !busy && req_ready, "R1 in reset",
              int'({spi_cs_n, spi_sclk, busy, req_ready}), 9);
        rst = 1'b0;
        @(negedge clk);
        check(spi_cs_n && !spi_sclk && !busy && req_ready, "R1 after reset",
              int'({spi_cs_n, spi_sclk, busy, req_ready}), 9);
        send(3, 0, 8, 1'b0, 1'b0, "R5");
        send(7, 5, 20, 1'b0, 1'b1, "R9");
        send(0, 90, 20, 1'b0, 1'b0, "R5");
        send(2, 14, 3, 1'b0, 1'b0, "R3");
        send(1, 95, 1, 1'b0, 1'b0, "R5");
        send(4, 10, 0, 1'b0, 1'b0, "R6");
        send(4, 100, 5, 1'b0, 1'b0, "R6");
        send(6, 40, 2, 1'b0, 1'b0, "R8");
        send(6, 42, 2, 1'b0, 1'b0, "R8");
        send(0, 0, 0, 1'b1, 1'b0, "R7");
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
        $finish;
    end
endmodule